// File: doc/BRIEF.md
# Pipelined Three-Tap Window Adder

This block adds three consecutive unsigned samples of a stream, one window per clock. The upstream logic presents three neighbouring samples in parallel together with a valid bit. The block registers the window, sums the first two samples in a first adder level, and holds the third sample in a delay register during that step. A second adder level then adds the held sample to the registered partial sum. Every output is therefore built from the operands of a single window. The block returns that sum with its own valid bit after a fixed latency.

A valid flag travels through a shift register that has the same depth as the data path. Idle slots in the input stream come out as idle slots at the output, in the same positions. Once the pipeline is full, one window is accepted and one result is produced on every cycle. The sum is two bits wider than a sample, so the largest possible window cannot overflow.

Top module: `wadd_top`

## Requirements
- R1: For each valid window, `sum_o` equals the unsigned sum `win_s0_i + win_s1_i + win_s2_i` at the full 10-bit width. The all-255 window gives 765.
- R2: If a valid window is presented in cycle 1 and is sampled on the following rising edge, its result shows on `sum_o` with `sum_valid_o` high in cycle 4. This is three rising edges later, and `sum_valid_o` is low in cycle 3.
- R3: Back-to-back valid windows with different contents each give the sum of their own three samples. No output combines the third sample of one window with the partial sum of another.
- R4: Valid windows can be presented on every cycle. A run of 100 consecutive windows yields 100 valid results, and the last one appears in cycle 103 when the first window is counted as cycle 1.
- R5: While `rst_ni` is low, `sum_valid_o` is 0 on every cycle after the first rising edge. Once reset is released, it stays 0 until the first valid window has passed through all three stages.
- R6: A cycle with `win_valid_i` low gives a cycle with `sum_valid_o` low three edges later, whatever data is on the sample inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all valid stages |
| win_valid_i | input | 1 | Window on the sample inputs is valid this cycle |
| win_s0_i | input | 8 | First sample of the window |
| win_s1_i | input | 8 | Second sample of the window |
| win_s2_i | input | 8 | Third sample of the window |
| sum_o | output | 10 | Sum of the three samples of the window from three cycles earlier |
| sum_valid_o | output | 1 | `sum_o` holds a valid result |

## Verification
The bench drives back-to-back windows in which the third sample changes every cycle. A design that skipped the delay register would add one window's third sample to another window's partial sum, and the reference model would catch the mismatch. The bench also checks the exact cycle in which the first result appears and the 103-cycle span of a 100-window run. A design with a stage missing or added in the data path or the valid path would fire one cycle early or late, and its count or span would be off. Further tests use all-255 windows to catch a sum that is too narrow. Alternating windows carry junk data in the idle slots, and a valid chain that leaked or filled in bubbles would report spurious results.

// File: rtl/wadd_pkg.sv
package wadd_pkg;
  parameter int unsigned SAMPLE_W = 8;
  localparam int unsigned TAPS    = 3;
  localparam int unsigned GROW_W  = $clog2(TAPS);
  localparam int unsigned LATENCY = 3;
endpackage

// File: rtl/wadd_capture.sv
module wadd_capture #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TAPS   = 3
) (
  input  logic                          clk_i,
  input  logic [TAPS-1:0][DATA_W-1:0]   win_i,
  output logic [TAPS-1:0][DATA_W-1:0]   win_q_o
);
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    always_ff @(posedge clk_i) win_q_o[t] <= win_i[t];
  end
endmodule

// File: rtl/wadd_level1.sv
module wadd_level1 #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SUM_W  = 10
) (
  input  logic              clk_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [SUM_W-1:0]  part_o,
  output logic [DATA_W-1:0] c_dly_o
);
  always_ff @(posedge clk_i) begin
    part_o  <= SUM_W'(a_i) + SUM_W'(b_i);
    // third operand waits one stage to stay with its partial sum
    c_dly_o <= c_i;
  end
endmodule

// File: rtl/wadd_level2.sv
module wadd_level2 #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SUM_W  = 10
) (
  input  logic              clk_i,
  input  logic [SUM_W-1:0]  part_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [SUM_W-1:0]  sum_o
);
  always_ff @(posedge clk_i) sum_o <= part_i + SUM_W'(c_i);
endmodule

// File: rtl/wadd_valid_pipe.sv
module wadd_valid_pipe #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic valid_o
);
  logic [DEPTH-1:0] v_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     v_q[k] <= 1'b0;
      else if (k == 0) v_q[k] <= valid_i;
      else             v_q[k] <= v_q[(k == 0) ? 0 : k-1];
    end
  end

  assign valid_o = v_q[DEPTH-1];

  // R5
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |=> (v_q == '0))
    else $error("valid chain not cleared by reset");
endmodule

// File: rtl/wadd_top.sv
module wadd_top #(
  parameter int unsigned DATA_W = wadd_pkg::SAMPLE_W,
  localparam int unsigned TAPS  = wadd_pkg::TAPS,
  localparam int unsigned SUM_W = DATA_W + wadd_pkg::GROW_W,
  localparam int unsigned LAT   = wadd_pkg::LATENCY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_valid_i,
  input  logic [DATA_W-1:0] win_s0_i,
  input  logic [DATA_W-1:0] win_s1_i,
  input  logic [DATA_W-1:0] win_s2_i,
  output logic [SUM_W-1:0]  sum_o,
  output logic              sum_valid_o
);
  logic [TAPS-1:0][DATA_W-1:0] win, win_q;
  logic [SUM_W-1:0]            part_q;
  logic [DATA_W-1:0]           c_dly_q;

  assign win = {win_s2_i, win_s1_i, win_s0_i};

  wadd_capture #(.DATA_W(DATA_W), .TAPS(TAPS)) u_capture (
    .clk_i   (clk_i),
    .win_i   (win),
    .win_q_o (win_q)
  );

  wadd_level1 #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_level1 (
    .clk_i   (clk_i),
    .a_i     (win_q[0]),
    .b_i     (win_q[1]),
    .c_i     (win_q[2]),
    .part_o  (part_q),
    .c_dly_o (c_dly_q)
  );

  wadd_level2 #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_level2 (
    .clk_i  (clk_i),
    .part_i (part_q),
    .c_i    (c_dly_q),
    .sum_o  (sum_o)
  );

  wadd_valid_pipe #(.DEPTH(LAT)) u_valid (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (win_valid_i),
    .valid_o (sum_valid_o)
  );

  // edges since reset release, saturating at the pipeline depth
  localparam int unsigned CNT_W = $clog2(LAT + 1);
  logic [CNT_W-1:0] since_rst_q;
  logic             primed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     since_rst_q <= '0;
    else if (since_rst_q != CNT_W'(LAT)) since_rst_q <= since_rst_q + 1'b1;
  end
  assign primed = (since_rst_q == CNT_W'(LAT));

  // R2
  lat_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && $past(win_valid_i, 3)) |-> sum_valid_o)
    else $error("valid window lost or late");

  // R6
  no_bubble_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && !$past(win_valid_i, 3)) |-> !sum_valid_o)
    else $error("output valid without input window");

  // R1
  sum_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && sum_valid_o) |->
      sum_o == $past(SUM_W'(win_s0_i) + SUM_W'(win_s1_i) + SUM_W'(win_s2_i), 3))
    else $error("window sum mismatch");
endmodule

// File: tb/wadd_top_bench.sv
`timescale 1ns/1ps
module wadd_top_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       win_valid_i = 1'b0;
  logic [7:0] win_s0_i = '0, win_s1_i = '0, win_s2_i = '0;
  logic [9:0] sum_o;
  logic       sum_valid_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int out_count = 0, last_out_cyc = 0;
  logic       ref_v [3] = '{1'b0, 1'b0, 1'b0};
  logic [9:0] ref_d [3] = '{10'd0, 10'd0, 10'd0};

  always #4 clk_i = ~clk_i;

  wadd_top u_wadd_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_valid_i(win_valid_i),
    .win_s0_i(win_s0_i), .win_s1_i(win_s1_i), .win_s2_i(win_s2_i),
    .sum_o(sum_o), .sum_valid_o(sum_valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model and per-cycle compare, at the falling edge
  always @(negedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) ref_v[i] = 1'b0;
    end else begin
      for (int i = 2; i > 0; i--) begin
        ref_v[i] = ref_v[i-1];
        ref_d[i] = ref_d[i-1];
      end
      ref_v[0] = win_valid_i;
      ref_d[0] = 10'(win_s0_i) + 10'(win_s1_i) + 10'(win_s2_i);
      if (ref_v[2] || sum_valid_o) begin
        chk(sum_valid_o == ref_v[2], "R6 valid", int'(sum_valid_o), int'(ref_v[2]));
        if (ref_v[2] && sum_valid_o)
          chk(sum_o == ref_d[2], "R1/R3 sum", int'(sum_o), int'(ref_d[2]));
      end
      if (sum_valid_o) begin
        out_count++;
        last_out_cyc = cyc;
      end
    end
  end

  task automatic drive(input logic v, input logic [7:0] a, b, c);
    @(negedge clk_i); #1;
    win_valid_i = v; win_s0_i = a; win_s1_i = b; win_s2_i = c;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'hA5, 8'h5A, 8'hFF);
  endtask

  task automatic t_reset;
    win_valid_i = 1'b1; win_s0_i = 8'd1; win_s1_i = 8'd2; win_s2_i = 8'd3;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      chk(sum_valid_o == 1'b0, "R5 in reset", int'(sum_valid_o), 0);
    end
    #1 win_valid_i = 1'b0;
    @(negedge clk_i); #2 rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(sum_valid_o == 1'b0, "R5 after release", int'(sum_valid_o), 0);
    end
  endtask

  task automatic t_latency;
    drive(1'b1, 8'd10, 8'd20, 8'd30);
    drive(1'b0, 8'd0, 8'd0, 8'd0);
    @(negedge clk_i); #1;
    chk(sum_valid_o == 1'b0, "R2 cycle 3", int'(sum_valid_o), 0);
    @(negedge clk_i); #1;
    chk(sum_valid_o == 1'b1, "R2 cycle 4 valid", int'(sum_valid_o), 1);
    chk(sum_o == 10'd60, "R2 cycle 4 data", int'(sum_o), 60);
    idle(3);
  endtask

  task automatic t_max;
    drive(1'b1, 8'd255, 8'd255, 8'd255);
    drive(1'b0, 8'd0, 8'd0, 8'd0);
    @(negedge clk_i); @(negedge clk_i); #1;
    chk(sum_o == 10'd765 && sum_valid_o, "R1 max", int'(sum_o), 765);
    idle(3);
  endtask

  task automatic t_back2back;
    // third sample varies strongly so misaligned operands show
    for (int i = 0; i < 12; i++)
      drive(1'b1, 8'(i), 8'(3*i + 1), 8'(i[0] ? 8'd250 : 8'(7*i)));
    idle(4);
  endtask

  task automatic t_gaps;
    for (int i = 0; i < 16; i++)
      drive(i[0], 8'(200 - i), 8'(i * 11), 8'(255 - 9*i));
    idle(4);
    chk(sum_valid_o == 1'b0, "R6 drained", int'(sum_valid_o), 0);
  endtask

  task automatic t_run100;
    int first_cyc, cnt0;
    cnt0 = out_count;
    for (int i = 0; i < 100; i++) begin
      drive(1'b1, 8'(i), 8'(i + 1), 8'(i + 2));
      if (i == 0) first_cyc = cyc;
    end
    idle(5);
    chk(out_count - cnt0 == 100, "R4 count", out_count - cnt0, 100);
    chk(last_out_cyc - first_cyc + 1 == 103, "R4 span", last_out_cyc - first_cyc + 1, 103);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_latency();
        t_max();
        t_back2back();
        t_gaps();
        t_run100();
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule